// File: doc/BRIEF.md
# Serial Byte Port with Status Word

This block is an asynchronous serial transmitter and receiver for single bytes, sitting behind a small register bus of four word addresses. Software writes a byte into a transmit holding register; the block moves it into a shift register and sends it on the serial line as a ten-bit frame. On the other side, a receive shift register assembles incoming frames and hands each finished byte to a receive data register, from which software reads it.

Both directions are double buffered: one byte may wait in the holding register while another is shifting out, and one received byte may wait in the data register while the next arrives. A read-only status word reports framing error, receive overrun, receive-full, transmit-full and transmitter-running, so software can poll rather than take interrupts. A divider register sets the bit rate; the receiver oversamples the line sixteen times per bit, confirms each start bit at its middle and samples every later bit at its middle.

Top module: `sio_port`

## Requirements
- R1: After reset the status word, the receive data register, the data-high register and the divider all read zero, and the serial output is high.
- R2: A transmitted frame is a low start bit, eight data bits least significant bit first, then a high stop bit; each bit lasts (divider + 1) x 16 clock cycles.
- R3: Word address 0 is the status word and ignores writes; address 1 is the data register (a read returns the received byte in bits 7:0 with bits 15:8 zero, a write offers a byte to transmit from bits 7:0); address 2 stores bits 15:8 of a write and returns them in bits 15:8; address 3 is the divider, read/write.
- R4: Status bit 4 is framing error, bit 3 overrun, bit 2 receive-full, bit 1 transmit-full, bit 0 transmitter-running; bits 15:5 read zero.
- R5: A write to the data register while transmit-full is clear is accepted and sets transmit-full; a write while transmit-full is set is dropped and that byte is never sent.
- R6: The holding register moves into the transmit shifter at the first bit boundary after the shifter is idle, clearing transmit-full; when a byte is waiting as a frame ends, the next start bit follows the stop bit with no gap, so frame starts are exactly 10 bit times apart.
- R7: Transmitter-running is high while the shifter sends a frame, and the serial output is high whenever it is low.
- R8: A received frame's data byte is placed in the receive data register and receive-full is set once its stop bit has been sampled.
- R9: Reading the data register clears receive-full.
- R10: On each transfer into the receive data register, overrun becomes 1 if receive-full was still set (unread data overwritten) and 0 otherwise.
- R11: On each transfer, framing error becomes 1 if the sampled stop bit was 0 and 0 if it was 1; it is unchanged between transfers.
- R12: The serial input passes a synchronizer; a low pulse that is high again at the middle of the start bit is dropped and no byte is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 status, 1 data, 2 data-high, 3 divider |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line |

## Verification
On every cycle the assertions check the flag rules: an accepted data write raises transmit-full, the line stays high while the transmitter is not running, a transfer raises receive-full and sets or clears overrun by whether unread data was present, a data read clears receive-full, and framing error moves only on a transfer. Only the bench scenarios can show the serial timing: bit order and period on the wire, the zero-gap spacing of back-to-back frames, dropping a write made while full, mid-bit sampling of incoming frames and the rejection of a short glitch.

// File: rtl/sio_pkg.sv
package sio_pkg;
   localparam logic [1:0] A_STAT = 2'd0;
   localparam logic [1:0] A_DATA = 2'd1;
   localparam logic [1:0] A_HIGH = 2'd2;
   localparam logic [1:0] A_DIV  = 2'd3;

   localparam int OVS = 16;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;
endpackage

// File: rtl/sio_tick.sv
module sio_tick #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= div) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + DIV_W'(1);
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_byte,
   output logic          full,
   output logic          running,
   output logic          line
);
   localparam int FW = DW + 2;
   localparam int NW = $clog2(FW);

   logic [3:0]    tph;
   logic [FW-1:0] sh;
   logic [NW-1:0] nbit;
   logic [DW-1:0] hold;
   logic          edge_b;

   assign edge_b = tick && (tph == 4'hF);
   assign line   = running ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tph     <= '0;
         sh      <= '1;
         nbit    <= '0;
         hold    <= '0;
         full    <= 1'b0;
         running <= 1'b0;
      end else begin
         if (tick) tph <= tph + 4'd1;
         if (wr_en && !full) begin
            hold <= wr_byte;
            full <= 1'b1;
         end
         if (edge_b) begin
            if (running && nbit != NW'(FW - 1)) begin
               sh   <= {1'b1, sh[FW-1:1]};
               nbit <= nbit + NW'(1);
            end else if (full) begin
               sh      <= {1'b1, hold, 1'b0};
               nbit    <= '0;
               full    <= 1'b0;
               running <= 1'b1;
            end else begin
               running <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
   import sio_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          rxd,
   output logic          load,
   output logic [DW-1:0] rx_byte,
   output logic          stop_ok
);
   localparam int BW = $clog2(DW);

   rx_state_e     st;
   logic [3:0]    cnt;
   logic [BW-1:0] nb;
   logic          prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RX_IDLE;
         cnt     <= '0;
         nb      <= '0;
         prev    <= 1'b1;
         load    <= 1'b0;
         rx_byte <= '0;
         stop_ok <= 1'b1;
      end else begin
         prev <= rxd;
         load <= 1'b0;
         unique case (st)
            RX_IDLE: if (prev && !rxd) begin
               st  <= RX_START;
               cnt <= '0;
            end
            RX_START: if (tick) begin
               if (cnt == 4'(OVS/2 - 1)) begin
                  cnt <= '0;
                  nb  <= '0;
                  st  <= rxd ? RX_IDLE : RX_DATA;
               end else cnt <= cnt + 4'd1;
            end
            RX_DATA: if (tick) begin
               if (cnt == 4'(OVS - 1)) begin
                  cnt     <= '0;
                  rx_byte <= {rxd, rx_byte[DW-1:1]};
                  if (nb == BW'(DW - 1)) st <= RX_STOP;
                  else nb <= nb + BW'(1);
               end else cnt <= cnt + 4'd1;
            end
            RX_STOP: if (tick) begin
               if (cnt == 4'(OVS - 1)) begin
                  load    <= 1'b1;
                  stop_ok <= rxd;
                  st      <= RX_IDLE;
               end else cnt <= cnt + 4'd1;
            end
            default: st <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sio_port.sv
module sio_port
   import sio_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [1:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   input  logic        ser_in,
   output logic        ser_out
);
   localparam int DW = 8;

   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("sio_port: DIV_W must lie in 1..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sio_port: SYNC_STAGES must be at least 2");
   end

   logic [DIV_W-1:0]       div_q;
   logic [DW-1:0]          high_q;
   logic [DW-1:0]          rx_data;
   logic                   rx_full, ovr, ferr;
   logic                   tick, tx_full, tx_run;
   logic                   rx_load, rx_stop_ok;
   logic [DW-1:0]          rx_byte;
   logic [SYNC_STAGES-1:0] sync_q;
   logic [4:0]             stat;
   logic                   wr_data, rd_data;

   assign wr_data = bus_sel && bus_wr && (bus_addr == A_DATA);
   assign rd_data = bus_sel && !bus_wr && (bus_addr == A_DATA);
   assign stat    = {ferr, ovr, rx_full, tx_full, tx_run};

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[i] <= 1'b1;
         else if (i == 0) sync_q[i] <= ser_in;
         else sync_q[i] <= sync_q[(i == 0) ? 0 : i - 1];
      end
   end

   sio_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
   );

   sio_tx #(.DW(DW)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_data),
      .wr_byte(bus_wdata[DW-1:0]), .full(tx_full), .running(tx_run),
      .line(ser_out)
   );

   sio_rx #(.DW(DW)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(sync_q[SYNC_STAGES-1]),
      .load(rx_load), .rx_byte(rx_byte), .stop_ok(rx_stop_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= '0;
         high_q  <= '0;
         rx_data <= '0;
         rx_full <= 1'b0;
         ovr     <= 1'b0;
         ferr    <= 1'b0;
      end else begin
         if (bus_sel && bus_wr && bus_addr == A_DIV)  div_q  <= bus_wdata[DIV_W-1:0];
         if (bus_sel && bus_wr && bus_addr == A_HIGH) high_q <= bus_wdata[15:8];
         if (rx_load) begin
            rx_data <= rx_byte;
            rx_full <= 1'b1;
            ovr     <= rx_full && !rd_data;
            ferr    <= !rx_stop_ok;
         end else if (rd_data) begin
            rx_full <= 1'b0;
         end
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_STAT:  bus_rdata = {11'd0, stat};
         A_DATA:  bus_rdata = {8'd0, rx_data};
         A_HIGH:  bus_rdata = {high_q, 8'd0};
         default: bus_rdata = 16'(div_q);
      endcase
   end
endmodule

module sio_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_sel,
   input logic       bus_wr,
   input logic [1:0] bus_addr,
   input logic [4:0] stat,
   input logic       rx_load,
   input logic       ser_out
);
   logic rd_d, wr_d;
   assign rd_d = bus_sel && !bus_wr && bus_addr == 2'd1;
   assign wr_d = bus_sel && bus_wr && bus_addr == 2'd1;

   // R7
   idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat[0] |-> ser_out);
   // R5
   accept_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_d && !stat[1]) |=> stat[1]);
   // R8
   load_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_load |=> stat[2]);
   // R9
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_d && !rx_load) |=> !stat[2]);
   // R10
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_load && stat[2] && !rd_d) |=> stat[3]);
   // R10
   ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_load && !stat[2]) |=> !stat[3]);
   // R11
   ferr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_load |=> $stable(stat[4]));
endmodule

bind sio_port sio_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .stat(stat), .rx_load(rx_load), .ser_out(ser_out)
);

// File: tb/sio_port_test.sv
`timescale 1ns/1ps
module sio_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        ser_in = 1'b1;
   logic        ser_out;

   int compared = 0, mismatched = 0;
   int cyc = 0;
   bit done = 1'b0;
   logic [7:0] txq[$];
   int starts[$];
   bit mon_busy = 1'b0;
   localparam int BITC = 32; // divider 1 -> (1+1)*16 clocks

   sio_port uut (.*);

   always #4 clk = ~clk;

   task automatic check(string req, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [1:0] a, logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic send_frame(logic [7:0] b, logic stop_bit);
      logic [9:0] f;
      f = {stop_bit, b, 1'b0};
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         ser_in = f[i];
         repeat (BITC - 1) @(negedge clk);
      end
      @(negedge clk);
      ser_in = 1'b1;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // cycle counter and watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         mismatched++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   // line monitor: behavioural decode of frames on ser_out (R2, R6)
   initial begin
      logic [7:0] b;
      logic [7:0] e;
      forever begin
         @(negedge clk);
         if (rst_n && ser_out == 1'b0) begin
            mon_busy = 1'b1;
            starts.push_back(cyc);
            repeat (BITC / 2) @(negedge clk);
            check("R2 start mid", ser_out, 0);
            for (int i = 0; i < 8; i++) begin
               repeat (BITC) @(negedge clk);
               b[i] = ser_out;
            end
            repeat (BITC) @(negedge clk);
            check("R2 stop bit", ser_out, 1);
            e = (txq.size() > 0) ? txq.pop_front() : 8'hxx;
            check("R2 byte on line", b, e);
            mon_busy = 1'b0;
         end
      end
   end

   // every clock: line must rest high when nothing is pending (R7)
   always @(negedge clk) begin
      if (rst_n && !mon_busy && txq.size() == 0 && !done) begin
         compared++;
         if (ser_out !== 1'b1) begin
            mismatched++;
            $display("FAIL R7 idle line actual=%0b expected=1", ser_out);
         end
      end
   end

   initial begin
      logic [15:0] r;
      // R1 reset state
      idle(3);
      check("R1 ser_out at reset", ser_out, 1);
      rst_n = 1'b1;
      idle(2);
      bus_read(2'd0, r); check("R1 status", r, 0);
      bus_read(2'd1, r); check("R1 data", r, 0);
      bus_read(2'd2, r); check("R1 data-high", r, 0);
      bus_read(2'd3, r); check("R1 divider", r, 0);

      // R3 map: divider, data-high storage, status read-only
      bus_write(2'd3, 16'h0001);
      bus_read(2'd3, r); check("R3 divider readback", r, 16'h0001);
      bus_write(2'd2, 16'h5A77);
      bus_read(2'd2, r); check("R3 data-high readback", r, 16'h5A00);
      bus_write(2'd0, 16'hFFFF);
      bus_read(2'd0, r); check("R3 status ignores write", r, 0);

      // R5 / R4: accepted write sets transmit-full (bit 1)
      txq.push_back(8'hA5);
      bus_write(2'd1, 16'h00A5);
      #1 check("R5 tx_full after write", uut.bus_rdata[1] & (bus_addr == 2'd0), 0);
      bus_read(2'd0, r); check("R4 tx_full bit1", r[1], 1);
      idle(40);
      bus_read(2'd0, r); check("R7 running bit0", r[1:0], 2'b01);
      wait (!mon_busy && txq.size() == 0);
      idle(3 * BITC);
      bus_read(2'd0, r); check("R7 idle status", r[1:0], 2'b00);

      // R6 back-to-back, R5 dropped write
      starts.delete();
      txq.push_back(8'h3C);
      bus_write(2'd1, 16'h003C);
      do bus_read(2'd0, r); while (r[1] == 1'b1);
      txq.push_back(8'h81);
      bus_write(2'd1, 16'h0081);
      bus_write(2'd1, 16'h00EE); // dropped: holding register full
      bus_read(2'd0, r); check("R5 still full", r[1], 1);
      wait (starts.size() == 2);
      check("R6 zero gap", starts[1] - starts[0], 10 * BITC);
      wait (!mon_busy && txq.size() == 0);
      idle(12 * BITC);
      check("R5 dropped byte not sent", starts.size(), 2);

      // R8 / R4 receive
      send_frame(8'h6B, 1'b1);
      idle(4);
      bus_read(2'd0, r); check("R8 rx_full, no errors", r[4:2], 3'b001);
      bus_read(2'd1, r); check("R8 data", r, 16'h006B);
      bus_read(2'd0, r); check("R9 rx_full cleared", r[2], 0);

      // R10 overrun on unread
      send_frame(8'h11, 1'b1);
      send_frame(8'hC2, 1'b1);
      idle(4);
      bus_read(2'd0, r); check("R10 overrun set", r[4:2], 3'b011);
      bus_read(2'd1, r); check("R10 newest byte kept", r, 16'h00C2);
      send_frame(8'h0F, 1'b1);
      idle(4);
      bus_read(2'd0, r); check("R10 overrun cleared", r[4:2], 3'b001);
      bus_read(2'd1, r); check("R8 data 2", r, 16'h000F);

      // R11 framing error set then cleared
      send_frame(8'h55, 1'b0);
      idle(BITC);
      bus_read(2'd0, r); check("R11 framing set", r[4:2], 3'b101);
      bus_read(2'd1, r); check("R11 data with bad stop", r, 16'h0055);
      send_frame(8'hAA, 1'b1);
      idle(4);
      bus_read(2'd0, r); check("R11 framing cleared", r[4:2], 3'b001);
      bus_read(2'd1, r);

      // R12 glitch rejection
      @(negedge clk); ser_in = 1'b0;
      idle(3);
      ser_in = 1'b1;
      idle(12 * BITC);
      bus_read(2'd0, r); check("R12 glitch no byte", r[2], 0);
      send_frame(8'h93, 1'b1);
      idle(4);
      bus_read(2'd1, r); check("R12 next byte after glitch", r, 16'h0093);

      idle(10);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule